// File: doc/BRIEF.md
# Fractional-Baud Serial Frame Transmitter

This block sends one 8-bit character per frame on an asynchronous serial line. A byte is offered on a valid/ready input. Once it is accepted, the block sends a low start bit, seven payload bits with the least significant bit first, and one top bit. It then sends one or two high stop bits and drops back to idle. The top bit carries one of three things. It can be the eighth data bit. It can be a computed even or odd parity bit over the seven low bits. In address mode it can be a per-byte mark flag. Parity wins when both parity and address mode are enabled.

Bit timing comes from an integer clock divisor plus a 5-bit fine adjustment in thirty-seconds of a bit. A phase accumulator adds the fine value once per bit period. Each time the accumulator wraps past 32, the next bit period is one clock longer, so the average period is divisor + fine/32 clocks. The divisor, the fine value, the stop-bit count and the whole frame content are captured when the byte is accepted. A divisor of zero blocks acceptance and leaves the line idle.

Top module: `frac_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, txLine is 1 and busy is 0.
- R2: An accepted frame appears on txLine as bit 0 = 0 (start), bits 1..7 = inData[0]..inData[6], bit 8 = top bit, and then stop bits of value 1: one stop bit (10 bits in total) when twoStop is 0, two stop bits (11 bits) when it is 1.
- R3: With parityEn = 0 and addrMode = 0, the top bit is inData[7].
- R4: With parityEn = 1, the top bit is a parity bit over inData[6:0]. With parityOdd = 0 the number of ones in inData[6:0] plus the parity bit is even; with parityOdd = 1 it is odd.
- R5: With parityEn = 0 and addrMode = 1, the top bit is inMark. With parityEn = 1 the parity bit is sent whatever the values of addrMode and inMark.
- R6: Frame bit k (k counts from 0 at the start bit) lasts D + floor((k+1)F/32) - floor(kF/32) clock cycles, where D is divisor and F is fineAdj as captured at acceptance.
- R7: inReady goes low in the cycle after a byte is accepted and stays low until the last stop bit has finished. Inputs applied while busy do not change the frame in flight.
- R8: While divisor is 0, inReady is 0, no byte is accepted and txLine stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Byte can be accepted this cycle |
| inData | input | 8 | Character to send |
| inMark | input | 1 | Address flag sent as the top bit in address mode |
| divisor | input | 16 | Integer clocks per bit period |
| fineAdj | input | 5 | Extra fraction of a bit period, in 1/32 steps |
| parityEn | input | 1 | Replace the top bit with parity |
| parityOdd | input | 1 | Parity type: 0 even, 1 odd |
| addrMode | input | 1 | Send inMark as the top bit |
| twoStop | input | 1 | Send two stop bits instead of one |
| txLine | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in flight |

## Verification
The hardest case to reach is the point where the fine accumulator wraps and stretches a single bit period by one cycle. That one-cycle slip only shows up if every clock of every bit is checked against a model of the accumulator. The bench therefore samples txLine in every cycle of the frame and compares it with an expected bit whose length it works out from the floor formula. It uses fine values of 1, 7, 16, 23 and 31 with small divisors, so that wraps land on different bit positions within one frame. A separate pass keeps inValid high during a frame with altered data and format inputs, to show that nothing leaks into the frame in flight.

// File: rtl/fbtx_pkg.sv
package fbtx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] LAST_ONE_STOP = IDX_W'(FRAME_BITS - 2);
  localparam logic [IDX_W-1:0] LAST_TWO_STOP = IDX_W'(FRAME_BITS - 1);

  typedef struct packed {
    logic load;
    logic shift;
    logic active;
  } txStrobe_t;
endpackage

// File: rtl/fbtx_baud.sv
module fbtx_baud #(
  parameter int DIV_W = 16,
  parameter int FRAC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] divIn,
  input  logic [FRAC_W-1:0] fracIn,
  output logic             bitEnd
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0]  divQ;
  logic [FRAC_W-1:0] fracQ;
  logic [FRAC_W-1:0] acc;
  logic              stretch;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [FRAC_W:0]   sum;

  assign limit  = {1'b0, divQ} - CNT_W'(1) + CNT_W'(stretch);
  assign sum    = {1'b0, acc} + {1'b0, fracQ};
  assign bitEnd = run && (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ    <= '0;
      fracQ   <= '0;
      acc     <= '0;
      stretch <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      divQ    <= divIn;
      fracQ   <= fracIn;
      acc     <= fracIn;
      stretch <= 1'b0;
      cnt     <= '0;
    end else if (run) begin
      if (cnt == limit) begin
        cnt     <= '0;
        acc     <= sum[FRAC_W-1:0];
        stretch <= sum[FRAC_W];
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R6: the period counter never passes the current period length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cnt <= limit));
  // R6: a stretched period needs a nonzero fine value
  a_r6_stretch_needs_frac: assert property (@(posedge clk) disable iff (!rstN)
    (run && stretch) |-> (fracQ != '0));
endmodule

// File: rtl/fbtx_ctrl.sv
module fbtx_ctrl
  import fbtx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      divIsZero,
  input  logic      twoStop,
  input  logic      bitEnd,
  output logic      inReady,
  output txStrobe_t strb
);
  logic             active;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             accept;

  assign inReady = !active && !divIsZero;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      bitIdx  <= '0;
      lastIdx <= LAST_ONE_STOP;
    end else if (accept) begin
      active  <= 1'b1;
      bitIdx  <= '0;
      lastIdx <= twoStop ? LAST_TWO_STOP : LAST_ONE_STOP;
    end else if (active && bitEnd) begin
      if (bitIdx == lastIdx) active <= 1'b0;
      else bitIdx <= bitIdx + IDX_W'(1);
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.shift  = active && bitEnd;
    strb.active = active;
  end

  // R7: no acceptance while a frame is in flight
  a_r7_ready_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !inReady);
  // R7: a frame only ends on a bit boundary
  a_r7_hold_until_end: assert property (@(posedge clk) disable iff (!rstN)
    (active && !bitEnd) |=> active);
  // R8: zero divisor blocks acceptance
  a_r8_zero_blocks: assert property (@(posedge clk) disable iff (!rstN)
    divIsZero |-> !inReady);
endmodule

// File: rtl/fbtx_datapath.sv
module fbtx_datapath
  import fbtx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  strb,
  input  logic [7:0] inData,
  input  logic       inMark,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       addrMode,
  output logic       txLine
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameVec;
  logic                  topBit;

  always_comb begin
    if (parityEn)      topBit = (^inData[6:0]) ^ parityOdd;
    else if (addrMode) topBit = inMark;
    else               topBit = inData[7];
    frameVec = {2'b11, topBit, inData[6:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '1;
    else if (strb.load)  shiftReg <= frameVec;
    else if (strb.shift) shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
  end

  assign txLine = shiftReg[0];

  // R1: the line idles high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> txLine);
  // R2: the first bit after acceptance is the low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !txLine);
endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx
  import fbtx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inMark,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] fineAdj,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              addrMode,
  input  logic              twoStop,
  output logic              txLine,
  output logic              busy
);
  txStrobe_t strb;
  logic      bitEnd;

  fbtx_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
    .clk(clk), .rstN(rstN), .start(strb.load), .run(strb.active),
    .divIn(divisor), .fracIn(fineAdj), .bitEnd(bitEnd));

  fbtx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .divIsZero(divisor == '0),
    .twoStop(twoStop), .bitEnd(bitEnd), .inReady(inReady), .strb(strb));

  fbtx_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .inMark(inMark),
    .parityEn(parityEn), .parityOdd(parityOdd), .addrMode(addrMode),
    .txLine(txLine));

  assign busy = strb.active;
endmodule

// File: tb/frac_uart_tx_bench.sv
module frac_uart_tx_bench;
  typedef struct packed {
    logic [7:0]  data;
    logic        mark;
    logic        pEn;
    logic        pOdd;
    logic        addr;
    logic        two;
    logic [15:0] div;
    logic [4:0]  fine;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd4, 5'd0},
    '{8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd3, 5'd16},
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd5, 5'd31},
    '{8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 5'd7},
    '{8'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd3, 5'd23},
    '{8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd4, 5'd1},
    '{8'h12, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1, 5'd31},
    '{8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'd2, 5'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inMark = 1'b0;
  logic [15:0] divisor = 16'd4;
  logic [4:0] fineAdj = '0;
  logic parityEn = 1'b0, parityOdd = 1'b0, addrMode = 1'b0, twoStop = 1'b0;
  logic inReady, txLine, busy;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  frac_uart_tx u_frac_uart_tx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inMark(inMark), .divisor(divisor), .fineAdj(fineAdj),
    .parityEn(parityEn), .parityOdd(parityOdd), .addrMode(addrMode),
    .twoStop(twoStop), .txLine(txLine), .busy(busy));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic expBit(input vec_t v, input int k);
    logic p;
    if (k == 0) return 1'b0;
    if (k <= 7) return v.data[k-1];
    if (k == 8) begin
      p = logic'($countones(v.data[6:0]) % 2) ^ v.pOdd;
      if (v.pEn) return p;
      if (v.addr) return v.mark;
      return v.data[7];
    end
    return 1'b1;
  endfunction

  function automatic int bitLen(input vec_t v, input int k);
    return int'(v.div) + ((k + 1) * int'(v.fine)) / 32 - (k * int'(v.fine)) / 32;
  endfunction

  task automatic sendFrame(input vec_t v, input bit hold, input string tag);
    int nBits;
    int bad;
    int badReady;
    int total;
    int firstBad;
    nBits = v.two ? 11 : 10;
    bad = 0; badReady = 0; total = 0; firstBad = -1;
    @(negedge clk);
    check(inReady === 1'b1, "R7 ready before frame", int'(inReady), 1);
    inData = v.data; inMark = v.mark; parityEn = v.pEn; parityOdd = v.pOdd;
    addrMode = v.addr; twoStop = v.two; divisor = v.div; fineAdj = v.fine;
    inValid = 1'b1;
    @(negedge clk);
    if (hold) begin
      inData = ~v.data; inMark = ~v.mark; parityEn = ~v.pEn;
      addrMode = ~v.addr; twoStop = ~v.two; divisor = v.div + 16'd3;
    end else begin
      inValid = 1'b0;
    end
    for (int k = 0; k < nBits; k++) begin
      for (int c = 0; c < bitLen(v, k); c++) begin
        total++;
        if (txLine !== expBit(v, k)) begin
          bad++;
          if (firstBad < 0) firstBad = k;
        end
        if (inReady !== 1'b0 || busy !== 1'b1) badReady++;
        if (k == nBits - 1 && c == bitLen(v, k) - 1) inValid = 1'b0;
        @(negedge clk);
      end
    end
    check(bad == 0, {"R2 ", tag, " R6 line bits/timing, first bad bit shown"}, firstBad, -1);
    check(badReady == 0, "R7 ready low and busy high through frame", badReady, 0);
    check(inReady === 1'b1 && busy === 1'b0 && txLine === 1'b1,
          "R6 R7 frame ends after exact cycle count", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0, "R1 line idle in reset", int'(txLine), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0 && inReady === 1'b1,
          "R1 idle after reset", int'(inReady), 1);

    for (int i = 0; i < NVEC; i++) begin
      sendFrame(VECS[i], 1'b0,
                VECS[i].pEn ? (VECS[i].addr ? "R5 R4" : "R4") :
                (VECS[i].addr ? "R5" : "R3"));
    end

    // R8: zero divisor blocks acceptance and keeps the line idle
    divisor = 16'd0;
    inValid = 1'b1;
    inData = 8'h55;
    begin
      int badZero = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (inReady !== 1'b0 || txLine !== 1'b1 || busy !== 1'b0) badZero++;
      end
      check(badZero == 0, "R8 zero divisor holds idle", badZero, 0);
    end
    inValid = 1'b0;
    divisor = 16'd3;
    @(negedge clk);
    check(inReady === 1'b1 && txLine === 1'b1, "R8 ready returns with divisor", int'(inReady), 1);

    // R7: inputs changed and valid held while busy do not alter the frame
    sendFrame('{8'h6B, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd3, 5'd9}, 1'b1, "R7 R3");
    sendFrame('{8'h2D, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd2, 5'd13}, 1'b1, "R7 R5");

    // R1: back-to-back idle after frames
    @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0, "R1 idle after frames", int'(txLine), 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule